// File: doc/BRIEF.md
# Hardware Transaction Nesting and Control Tracker

This block follows the transactional state of one processor core while decoded transaction-begin, transaction-end and abort events arrive in program order. It keeps the nesting depth and the effective controls of the whole nest. Those controls are a permission bit for writes to the access-register class, a permission bit for writes to the floating-point register class, and an interruption-filter level. The block latches the register-pair save mask when the outermost begin arrives. It reports a commit pulse when the outermost transaction ends, and an abort pulse with a condition code and a restart selector when the nest is thrown away.

Nesting is closed and flattened. Inner ends only pop a level. Any abort, from any level, returns the core to depth 0. The effective controls are kept per level, so an inner end restores the controls that the enclosing levels had. A constrained transaction may only be opened from depth 0. It runs with floating-point writes and filtering disabled. When it aborts, execution restarts at the constrained begin itself and not at the instruction after it. A begin and an end are not expected in the same cycle. If both arrive, the begin is taken and the end is dropped. All outputs change on the clock edge that samples the causing input.

Top module: `txn_nest_tracker`

## Requirements
- R1: After reset the depth is 0, in_tx, in_constr, commit_p, abort_p, end_err and restart_at_begin are 0, abort_cc is 0, and the effective controls read permit-AR 1, permit-FP 1, filter 0.
- R2: An accepted begin raises depth by 1 and an end at depth 2 or more lowers it by 1 without a commit pulse. in_tx is 1 exactly when depth is not 0.
- R3: A begin that arrives at depth 16 (MAX_DEPTH) aborts the nest with condition code 3.
- R4: An end at depth 1 gives a one-cycle commit_p, sets depth to 0 and clears in_tx and in_constr.
- R5: Any abort gives a one-cycle abort_p and forces depth to 0. For a non-constrained nest, restart_at_begin is 0, which selects restart after the outermost begin.
- R6: The effective permit-AR and permit-FP bits are the AND of the bits of every begin still open. An inner end restores the values of the enclosing level.
- R7: Inside a transaction, a write attempt (ar_write or fp_write) to a class whose effective permit bit is 0 aborts with code 3. A write attempt to a permitted class has no effect.
- R8: The effective filter level is the maximum over the open begins. A requested level of 3 counts as 2.
- R9: save_mask is loaded from beg_save_mask only by the begin at depth 0. Nested begins leave it unchanged.
- R10: A constrained begin at depth 0 sets in_constr, forces permit-FP to 0 and the filter to 0, and keeps its own permit-AR bit. An abort of that transaction reports restart_at_begin 1.
- R11: A constrained begin inside a non-constrained transaction is taken as an ordinary nested begin and uses its own fields. Any begin inside a constrained transaction aborts with code 3.
- R12: An explicit abort reports code 2 when bit 0 of its abort code is 0 and code 3 when that bit is 1. An external abort reports 3 when ext_abort_perm is 1 and 2 otherwise. When several causes coincide, the external code wins, then the explicit code, then the fixed code 3.
- R13: An abort in the same cycle as a committing end wins: abort_p is raised and commit_p is not. Explicit and external aborts at depth 0 are ignored.
- R14: An end at depth 0 changes no state and gives a one-cycle end_err pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| beg_vld | input | 1 | Decoded transaction begin |
| beg_constr | input | 1 | Begin is the constrained form |
| beg_ar_ok | input | 1 | Begin permits access-register writes |
| beg_fp_ok | input | 1 | Begin permits floating-point register writes |
| beg_filt | input | 2 | Requested interruption-filter level |
| beg_save_mask | input | 8 | Register-pair save mask of the begin |
| end_vld | input | 1 | Decoded transaction end |
| xabort_vld | input | 1 | Explicit abort instruction |
| xabort_code | input | ABORT_CODE_W | Explicit abort code; bit 0 picks the condition code |
| ar_write | input | 1 | Instruction attempts an access-register write |
| fp_write | input | 1 | Instruction attempts a floating-point register write |
| ext_abort_vld | input | 1 | External abort request (conflict, interrupt, overflow) |
| ext_abort_perm | input | 1 | External cause is permanent |
| depth | output | DW | Current nesting depth |
| in_tx | output | 1 | Transactional mode |
| in_constr | output | 1 | Current nest is constrained |
| eff_ar_ok | output | 1 | Effective access-register write permission |
| eff_fp_ok | output | 1 | Effective floating-point write permission |
| eff_filt | output | 2 | Effective interruption-filter level |
| save_mask | output | 8 | Save mask captured at the outermost begin |
| commit_p | output | 1 | Commit pulse |
| abort_p | output | 1 | Abort pulse |
| abort_cc | output | 2 | Condition code of the abort (0 when no abort) |
| restart_at_begin | output | 1 | With abort_p: 1 restarts at the constrained begin, 0 after the outermost begin |
| end_err | output | 1 | End received outside a transaction |

## Verification
The bench sweeps every pair of outer and inner control settings through a begin, begin, end, end sequence. It runs every depth from 1 to 16 into an abort, and the 16th level into one more begin. A design with a single running merge instead of a per-level stack would keep the inner level's restrictions after the inner end. A design with an off-by-one limit would abort at depth 15 or let depth reach 17. The constrained cases cover a begin inside a constrained nest, which must abort, and a constrained begin inside a normal nest, which must nest. A swapped restart selector or a missed forcing of the floating-point permission shows up there. The bench also drives an abort together with a committing end, an end at depth 0, and aborts outside any transaction. A design that lets commit win, or lets the orphan end wrap the depth, fails these cases.

// File: rtl/txn_pkg.sv
package txn_pkg;

  typedef struct packed {
    logic       ar_ok;
    logic       fp_ok;
    logic [1:0] filt;
  } ctl_t;

  localparam ctl_t CTL_IDLE = '{ar_ok: 1'b1, fp_ok: 1'b1, filt: 2'd0};

  localparam logic [1:0] CC_NONE      = 2'd0;
  localparam logic [1:0] CC_TRANSIENT = 2'd2;
  localparam logic [1:0] CC_PERMANENT = 2'd3;

  // Requested filter levels above 2 saturate at 2.
  function automatic logic [1:0] filt_clip(input logic [1:0] f);
    return (f == 2'd3) ? 2'd2 : f;
  endfunction

  function automatic logic [1:0] filt_max(input logic [1:0] a, input logic [1:0] b);
    return (a > b) ? a : b;
  endfunction

  // Combine the controls of the enclosing level with a new begin.
  function automatic ctl_t ctl_merge(input ctl_t outer, input ctl_t inner);
    ctl_t r;
    r.ar_ok = outer.ar_ok & inner.ar_ok;
    r.fp_ok = outer.fp_ok & inner.fp_ok;
    r.filt  = filt_max(outer.filt, filt_clip(inner.filt));
    return r;
  endfunction

  function automatic logic [1:0] cc_from_flag(input logic permanent);
    return permanent ? CC_PERMANENT : CC_TRANSIENT;
  endfunction

endpackage

// File: rtl/txn_depth_ctr.sv
module txn_depth_ctr #(
  parameter int MAX_DEPTH = 16,
  localparam int DW = $clog2(MAX_DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  input  logic          dec,
  input  logic          flush,
  output logic [DW-1:0] depth
);

  logic [DW-1:0] depth_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      depth_q <= '0;
    else if (flush)  depth_q <= '0;
    else if (inc)    depth_q <= depth_q + DW'(1);
    else if (dec)    depth_q <= depth_q - DW'(1);
  end

  assign depth = depth_q;

endmodule

// File: rtl/txn_ctl_stack.sv
module txn_ctl_stack
  import txn_pkg::*;
#(
  parameter int MAX_DEPTH = 16,
  localparam int DW = $clog2(MAX_DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] depth,
  input  ctl_t          new_ctl,
  output ctl_t          eff_ctl
);

  ctl_t lvl_w [MAX_DEPTH];

  for (genvar g = 0; g < MAX_DEPTH; g++) begin : g_lvl
    ctl_t lvl_q;
    ctl_t base;
    if (g == 0) begin : g_first
      assign base = CTL_IDLE;
    end else begin : g_rest
      assign base = lvl_w[g-1];
    end
    always_ff @(posedge clk) begin
      if (!rst_n)                            lvl_q <= CTL_IDLE;
      else if (push && (depth == DW'(g)))    lvl_q <= ctl_merge(base, new_ctl);
    end
    assign lvl_w[g] = lvl_q;
  end

  always_comb begin
    eff_ctl = CTL_IDLE;
    for (int i = 0; i < MAX_DEPTH; i++) begin
      if (depth == DW'(i + 1)) eff_ctl = lvl_w[i];
    end
  end

endmodule

// File: rtl/txn_abort_sel.sv
module txn_abort_sel
  import txn_pkg::*;
(
  input  logic       ext_req,
  input  logic       ext_perm,
  input  logic       xab_req,
  input  logic       xab_lsb,
  input  logic       perm_req,
  output logic       abort_any,
  output logic [1:0] cc
);

  always_comb begin
    abort_any = ext_req | xab_req | perm_req;
    if (ext_req)       cc = cc_from_flag(ext_perm);
    else if (xab_req)  cc = cc_from_flag(xab_lsb);
    else if (perm_req) cc = CC_PERMANENT;
    else               cc = CC_NONE;
  end

endmodule

// File: rtl/txn_nest_tracker.sv
module txn_nest_tracker
  import txn_pkg::*;
#(
  parameter int MAX_DEPTH    = 16,
  parameter int ABORT_CODE_W = 16,
  localparam int DW = $clog2(MAX_DEPTH + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    beg_vld,
  input  logic                    beg_constr,
  input  logic                    beg_ar_ok,
  input  logic                    beg_fp_ok,
  input  logic [1:0]              beg_filt,
  input  logic [7:0]              beg_save_mask,
  input  logic                    end_vld,
  input  logic                    xabort_vld,
  input  logic [ABORT_CODE_W-1:0] xabort_code,
  input  logic                    ar_write,
  input  logic                    fp_write,
  input  logic                    ext_abort_vld,
  input  logic                    ext_abort_perm,
  output logic [DW-1:0]           depth,
  output logic                    in_tx,
  output logic                    in_constr,
  output logic                    eff_ar_ok,
  output logic                    eff_fp_ok,
  output logic [1:0]              eff_filt,
  output logic [7:0]              save_mask,
  output logic                    commit_p,
  output logic                    abort_p,
  output logic [1:0]              abort_cc,
  output logic                    restart_at_begin,
  output logic                    end_err
);

  logic [DW-1:0] depth_w;
  ctl_t          eff_w;
  ctl_t          push_ctl;
  logic          constr_q;
  logic [7:0]    mask_q;
  logic          commit_q, abort_q, rs_q, err_q;
  logic [1:0]    cc_q;

  // Named internal events
  logic       tx_active;
  logic       ev_beg_in_constr;
  logic       ev_beg_ovf;
  logic       ev_restrict;
  logic       ev_xabort;
  logic       ev_ext;
  logic       abort_any;
  logic [1:0] abort_cc_w;
  logic       ev_beg_ok;
  logic       ev_beg_outer;
  logic       ev_end_pop;
  logic       ev_commit;
  logic       ev_end_orphan;

  assign tx_active        = (depth_w != '0);
  assign ev_beg_in_constr = beg_vld & tx_active & constr_q;
  assign ev_beg_ovf       = beg_vld & tx_active & (depth_w == DW'(MAX_DEPTH));
  assign ev_restrict      = tx_active & ((ar_write & ~eff_w.ar_ok) | (fp_write & ~eff_w.fp_ok));
  assign ev_xabort        = xabort_vld & tx_active;
  assign ev_ext           = ext_abort_vld & tx_active;

  txn_abort_sel u_abort_sel (
    .ext_req  (ev_ext),
    .ext_perm (ext_abort_perm),
    .xab_req  (ev_xabort),
    .xab_lsb  (xabort_code[0]),
    .perm_req (ev_beg_in_constr | ev_beg_ovf | ev_restrict),
    .abort_any(abort_any),
    .cc       (abort_cc_w)
  );

  assign ev_beg_ok     = beg_vld & ~abort_any;
  assign ev_beg_outer  = ev_beg_ok & ~tx_active;
  assign ev_end_pop    = end_vld & ~beg_vld & tx_active & ~abort_any;
  assign ev_commit     = ev_end_pop & (depth_w == DW'(1));
  assign ev_end_orphan = end_vld & ~beg_vld & ~tx_active;

  // A constrained begin at depth 0 disables floating-point writes and filtering.
  always_comb begin
    push_ctl.ar_ok = beg_ar_ok;
    if (ev_beg_outer && beg_constr) begin
      push_ctl.fp_ok = 1'b0;
      push_ctl.filt  = 2'd0;
    end else begin
      push_ctl.fp_ok = beg_fp_ok;
      push_ctl.filt  = beg_filt;
    end
  end

  txn_depth_ctr #(.MAX_DEPTH(MAX_DEPTH)) u_depth (
    .clk  (clk),
    .rst_n(rst_n),
    .inc  (ev_beg_ok),
    .dec  (ev_end_pop),
    .flush(abort_any),
    .depth(depth_w)
  );

  txn_ctl_stack #(.MAX_DEPTH(MAX_DEPTH)) u_stack (
    .clk    (clk),
    .rst_n  (rst_n),
    .push   (ev_beg_ok),
    .depth  (depth_w),
    .new_ctl(push_ctl),
    .eff_ctl(eff_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      constr_q <= 1'b0;
      mask_q   <= '0;
    end else begin
      if (abort_any || ev_commit) constr_q <= 1'b0;
      else if (ev_beg_outer)      constr_q <= beg_constr;
      if (ev_beg_outer)           mask_q   <= beg_save_mask;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      commit_q <= 1'b0;
      abort_q  <= 1'b0;
      cc_q     <= CC_NONE;
      rs_q     <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      commit_q <= ev_commit;
      abort_q  <= abort_any;
      cc_q     <= abort_cc_w;
      rs_q     <= abort_any & constr_q;
      err_q    <= ev_end_orphan;
    end
  end

  assign depth            = depth_w;
  assign in_tx            = tx_active;
  assign in_constr        = constr_q;
  assign eff_ar_ok        = eff_w.ar_ok;
  assign eff_fp_ok        = eff_w.fp_ok;
  assign eff_filt         = eff_w.filt;
  assign save_mask        = mask_q;
  assign commit_p         = commit_q;
  assign abort_p          = abort_q;
  assign abort_cc         = cc_q;
  assign restart_at_begin = rs_q;
  assign end_err          = err_q;

endmodule

module txn_nest_tracker_chk #(
  parameter int MAX_DEPTH = 16,
  localparam int DW = $clog2(MAX_DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [DW-1:0] depth,
  input logic          in_tx,
  input logic          in_constr,
  input logic          eff_fp_ok,
  input logic [1:0]    eff_filt,
  input logic [7:0]    save_mask,
  input logic          commit_p,
  input logic          abort_p,
  input logic [1:0]    abort_cc,
  input logic          end_err,
  input logic          abort_any,
  input logic          ev_commit
);

  // R2
  depth_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (depth != $past(depth)) |-> (abort_p || depth == $past(depth) + DW'(1) || depth == $past(depth) - DW'(1)));

  // R3
  depth_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    depth <= DW'(MAX_DEPTH));

  // R4
  commit_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_commit |=> (commit_p && depth == '0 && !in_tx));

  // R5
  abort_flat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_p |-> (depth == '0 && !in_constr));

  // R9
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_tx && $past(in_tx)) |-> $stable(save_mask));

  // R10
  constr_ctl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_constr |-> (!eff_fp_ok && eff_filt == 2'd0));

  // R12
  abort_cc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_p |-> abort_cc[1]);

  // R13
  abort_over_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_any |=> (abort_p && !commit_p));

  // R14
  orphan_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    end_err |-> (depth == '0 && $stable(depth)));

endmodule

bind txn_nest_tracker txn_nest_tracker_chk #(.MAX_DEPTH(MAX_DEPTH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .depth    (depth),
  .in_tx    (in_tx),
  .in_constr(in_constr),
  .eff_fp_ok(eff_fp_ok),
  .eff_filt (eff_filt),
  .save_mask(save_mask),
  .commit_p (commit_p),
  .abort_p  (abort_p),
  .abort_cc (abort_cc),
  .end_err  (end_err),
  .abort_any(abort_any),
  .ev_commit(ev_commit)
);

// File: tb/txn_nest_tracker_tb.sv
`timescale 1ns/1ps
module txn_nest_tracker_tb;

  localparam int MAXD = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        beg_vld = 0, beg_constr = 0, beg_ar_ok = 0, beg_fp_ok = 0;
  logic [1:0]  beg_filt = 0;
  logic [7:0]  beg_save_mask = 0;
  logic        end_vld = 0, xabort_vld = 0, ar_write = 0, fp_write = 0;
  logic [15:0] xabort_code = 0;
  logic        ext_abort_vld = 0, ext_abort_perm = 0;
  logic [4:0]  depth;
  logic        in_tx, in_constr, eff_ar_ok, eff_fp_ok;
  logic [1:0]  eff_filt;
  logic [7:0]  save_mask;
  logic        commit_p, abort_p;
  logic [1:0]  abort_cc;
  logic        restart_at_begin, end_err;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  // Bench model: level 0 is the idle state.
  int m_depth = 0;
  bit m_con = 0;
  bit m_ar [0:MAXD];
  bit m_fp [0:MAXD];
  int m_fl [0:MAXD];
  logic [7:0] m_mask = 0;

  always #2 clk = ~clk;

  txn_nest_tracker u_dut (
    .clk(clk), .rst_n(rst_n), .beg_vld(beg_vld), .beg_constr(beg_constr),
    .beg_ar_ok(beg_ar_ok), .beg_fp_ok(beg_fp_ok), .beg_filt(beg_filt),
    .beg_save_mask(beg_save_mask), .end_vld(end_vld), .xabort_vld(xabort_vld),
    .xabort_code(xabort_code), .ar_write(ar_write), .fp_write(fp_write),
    .ext_abort_vld(ext_abort_vld), .ext_abort_perm(ext_abort_perm),
    .depth(depth), .in_tx(in_tx), .in_constr(in_constr), .eff_ar_ok(eff_ar_ok),
    .eff_fp_ok(eff_fp_ok), .eff_filt(eff_filt), .save_mask(save_mask),
    .commit_p(commit_p), .abort_p(abort_p), .abort_cc(abort_cc),
    .restart_at_begin(restart_at_begin), .end_err(end_err)
  );

  function automatic logic [24:0] pack_exp(bit c, bit a, int cc, bit rs, bit er);
    logic [4:0] d;
    logic [1:0] f;
    logic [1:0] ccv;
    d   = 5'(m_depth);
    f   = 2'(m_fl[m_depth]);
    ccv = 2'(cc);
    return {d, (m_depth > 0), m_con, m_ar[m_depth], m_fp[m_depth], f, m_mask, c, a, ccv, rs, er};
  endfunction

  function automatic logic [24:0] pack_act();
    return {depth, in_tx, in_constr, eff_ar_ok, eff_fp_ok, eff_filt, save_mask,
            commit_p, abort_p, abort_cc, restart_at_begin, end_err};
  endfunction

  task automatic clear_inputs();
    beg_vld = 0; beg_constr = 0; beg_ar_ok = 0; beg_fp_ok = 0; beg_filt = 0;
    beg_save_mask = 0; end_vld = 0; xabort_vld = 0; xabort_code = 0;
    ar_write = 0; fp_write = 0; ext_abort_vld = 0; ext_abort_perm = 0;
  endtask

  task automatic model_reset();
    m_depth = 0; m_con = 0; m_mask = 0;
    m_ar[0] = 1; m_fp[0] = 1; m_fl[0] = 0;
  endtask

  // Predict the next state from the inputs, take one edge, compare.
  task automatic step(input string tag);
    bit in_t, ab, c, er, rs;
    int cc, rq, nl;
    logic [24:0] ex, ac;
    in_t = (m_depth > 0);
    ab = 0; cc = 0; c = 0; er = 0;
    if (in_t) begin
      if (ext_abort_vld) begin ab = 1; cc = ext_abort_perm ? 3 : 2; end
      else if (xabort_vld) begin ab = 1; cc = xabort_code[0] ? 3 : 2; end
      else if ((ar_write && !m_ar[m_depth]) || (fp_write && !m_fp[m_depth]) ||
               (beg_vld && (m_con || m_depth == MAXD))) begin ab = 1; cc = 3; end
    end
    rs = ab && m_con;
    if (ab) begin
      m_depth = 0; m_con = 0;
    end else if (beg_vld) begin
      nl = m_depth + 1;
      rq = (beg_filt == 2'd3) ? 2 : int'(beg_filt);
      m_ar[nl] = m_ar[m_depth] & beg_ar_ok;
      if (m_depth == 0 && beg_constr) begin
        m_fp[nl] = 0; m_fl[nl] = 0;
      end else begin
        m_fp[nl] = m_fp[m_depth] & beg_fp_ok;
        m_fl[nl] = (m_fl[m_depth] > rq) ? m_fl[m_depth] : rq;
      end
      if (m_depth == 0) begin m_mask = beg_save_mask; m_con = beg_constr; end
      m_depth = nl;
    end else if (end_vld) begin
      if (m_depth == 0) er = 1;
      else begin
        m_depth = m_depth - 1;
        if (m_depth == 0) begin c = 1; m_con = 0; end
      end
    end
    ex = pack_exp(c, ab, cc, rs, er);
    @(posedge clk);
    #1;
    ac = pack_act();
    n_tests++;
    if (ac !== ex) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h (depth,tx,con,ar,fp,filt,mask,commit,abort,cc,rs,err)",
               tag, ac, ex);
    end
    clear_inputs();
  endtask

  task automatic do_begin(input bit con, input bit ar, input bit fp, input logic [1:0] fl,
                          input logic [7:0] mk, input string tag);
    beg_vld = 1; beg_constr = con; beg_ar_ok = ar; beg_fp_ok = fp; beg_filt = fl;
    beg_save_mask = mk;
    step(tag);
  endtask

  task automatic do_end(input string tag);
    end_vld = 1; step(tag);
  endtask

  task automatic do_ext(input bit perm, input string tag);
    ext_abort_vld = 1; ext_abort_perm = perm; step(tag);
  endtask

  task automatic do_xab(input logic [15:0] code, input string tag);
    xabort_vld = 1; xabort_code = code; step(tag);
  endtask

  task automatic do_wr(input bit a, input bit f, input string tag);
    ar_write = a; fp_write = f; step(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    model_reset();
    clear_inputs();
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1 reset state
    step("R1 reset state");

    // R2 R9 basic nesting, mask only from the outermost begin
    do_begin(0, 1, 1, 2'd1, 8'hA5, "R2 R9 outer begin");
    do_begin(0, 1, 1, 2'd0, 8'h3C, "R2 R9 nested begin keeps mask");
    do_begin(0, 1, 1, 2'd0, 8'hFF, "R2 R9 third begin");
    do_end("R2 inner end");
    do_end("R2 inner end");
    do_end("R4 end at depth 1 commits");
    step("R4 commit is one cycle");

    // R6 R8 sweep of every outer/inner control pair
    for (int o = 0; o < 16; o++) begin
      for (int i = 0; i < 16; i++) begin
        do_begin(0, o[3], o[2], o[1:0], 8'(o * 16 + i), "R6 R8 outer");
        do_begin(0, i[3], i[2], i[1:0], 8'(i), "R6 R8 R9 inner merge");
        do_end("R6 inner end restores");
        do_end("R4 commit after sweep");
      end
    end

    // R3 R5 every depth, then abort or overflow
    for (int n = 1; n <= MAXD; n++) begin
      for (int k = 0; k < n; k++) do_begin(0, 1, 1, 2'(k % 3), 8'(n), "R2 climb");
      if (n == MAXD) do_begin(0, 1, 1, 2'd0, 8'h00, "R3 begin at depth 16 aborts");
      else           do_ext(n[0], "R5 R12 external abort flattens");
    end

    // R7 restricted writes
    do_begin(0, 0, 1, 2'd0, 8'h11, "R7 outer");
    do_wr(0, 1, "R7 permitted fp write ignored");
    do_wr(1, 0, "R7 forbidden ar write aborts");
    do_begin(0, 1, 1, 2'd0, 8'h12, "R7 outer");
    do_begin(0, 1, 0, 2'd0, 8'h13, "R7 inner forbids fp");
    do_wr(1, 0, "R7 permitted ar write ignored");
    do_wr(0, 1, "R7 forbidden fp write aborts");
    do_wr(1, 1, "R7 writes outside tx ignored");

    // R10 constrained transaction
    do_begin(1, 1, 1, 2'd2, 8'h77, "R10 constrained begin forces fp and filt");
    do_wr(1, 0, "R10 ar write allowed");
    do_ext(0, "R10 abort restarts at begin");
    do_begin(1, 1, 1, 2'd1, 8'h78, "R10 constrained begin");
    do_end("R4 R10 constrained commit");

    // R11 nesting rules
    do_begin(1, 0, 0, 2'd0, 8'h21, "R11 constrained outer");
    do_begin(0, 1, 1, 2'd0, 8'h22, "R11 begin inside constrained aborts");
    do_begin(0, 1, 1, 2'd1, 8'h23, "R11 normal outer");
    do_begin(1, 1, 0, 2'd2, 8'h24, "R11 constrained begin nests normally");
    do_end("R11 inner end");
    do_xab(16'h0002, "R5 R12 explicit abort even code");

    // R12 condition codes
    do_begin(0, 1, 1, 2'd0, 8'h31, "R12 outer");
    do_xab(16'h8001, "R12 explicit abort odd code");
    do_begin(0, 1, 1, 2'd0, 8'h32, "R12 outer");
    ext_abort_vld = 1; ext_abort_perm = 0; xabort_vld = 1; xabort_code = 16'h0001;
    step("R12 external code wins over explicit");
    do_begin(0, 0, 1, 2'd0, 8'h33, "R12 outer");
    xabort_vld = 1; xabort_code = 16'h0000; ar_write = 1;
    step("R12 explicit code wins over restricted");

    // R13 abort beats commit; aborts outside tx ignored
    do_begin(0, 1, 1, 2'd0, 8'h41, "R13 outer");
    end_vld = 1; ext_abort_vld = 1; ext_abort_perm = 1;
    step("R13 abort wins over commit");
    do_ext(1, "R13 external abort at depth 0 ignored");
    do_xab(16'h0001, "R13 explicit abort at depth 0 ignored");

    // R14 orphan end
    do_end("R14 end at depth 0 flags error");
    step("R14 error is one cycle");
    do_begin(0, 1, 1, 2'd0, 8'h51, "R14 outer after orphan");
    do_end("R4 R14 commit after orphan");

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule